// File: doc/BRIEF.md
# Dual-Channel Write Latch Interface

This block is the digital front end of a two-channel converter, modelled as synchronous logic. A host writes to it over one shared 8-bit data port. It also drives a channel-select line, an active-low chip select and an active-low write strobe. A system clock samples all of these asynchronous pins through a multi-stage synchroniser. The block then drives the two held channel codes to the analog side.

A register is transparent while chip select and strobe are both low and it is the one selected. Its code then follows the data port continuously. When either control returns high, the register keeps the last value it sampled. The other channel is not touched at any time.

The block also acts as a bus-timing monitor, counting in system-clock cycles. It checks the setup of chip select, select and data before the strobe ends, their hold after it, the strobe pulse width, and any select change in the middle of a write. Each rule has its own sticky violation flag. A write that breaks a rule still updates its register.

Top module: `dual_latch_front`

## Requirements
- R1: After reset both channel codes read 8'h00 and all eight violation flags read 0.
- R2: A write with `ch_sel` low loads channel A (`code_a`), and a write with `ch_sel` high loads channel B (`code_b`).
- R3: While `cs_n` and `wr_n` are both low, the selected code follows `din`. A change on `din` shows on the code three clock edges after the pin changes.
- R4: When `cs_n` or `wr_n` is high, neither code changes. After a strobe ends, the selected code keeps the value that was sampled in the last active cycle.
- R5: The register that is not selected is never changed by a write.
- R6: Flag bit 0 sets when the active strobe lasted fewer than `PW_CYC` cycles.
- R7: Flag bits 1, 2 and 3 (chip select, select, data) set when that signal has been stable for fewer than `SETUP_CYC` cycles at the cycle the strobe ends.
- R8: Flag bits 4, 5 and 6 (chip select, select, data) set when that signal changes in the strobe-end cycle or within the `HOLD_CYC` cycles after it.
- R9: Flag bit 7 sets when `ch_sel` changes during an active strobe. From that cycle on, data goes only to the newly selected register.
- R10: Flags are sticky until `viol_clr`, which is synchronous and wins over a new violation in the same cycle.
- R11: A write that raises any violation flag still updates its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_clr | input | 1 | Synchronous clear of all violation flags |
| din | input | 8 | Shared data port (asynchronous) |
| ch_sel | input | 1 | Channel select: 0 = A, 1 = B (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| code_a | output | 8 | Held code of channel A |
| code_b | output | 8 | Held code of channel B |
| viol | output | 8 | Sticky violation flags, bit meanings per R6 to R9 |

## Verification
The select line can flip while the strobe is still active. In that one cycle the block does two things: it routes data to a different register and it raises the mid-write flag. The bench provokes this by holding a write open and toggling `ch_sel`. It judges both codes and the flag byte at once: the old register keeps its value, the new one takes the data, and bit 7 is set. A second overlap is a write whose strobe end coincides with a chip-select rise. This drives a register update and a hold violation from the same edge, and the bench checks the data and the flag together.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
   localparam int NVIOL       = 8;
   localparam int V_PW        = 0;
   localparam int V_SU_BASE   = 1;   // cs, sel, data at 1..3
   localparam int V_HO_BASE   = 4;   // cs, sel, data at 4..6
   localparam int V_SEL_MID   = 7;
   localparam int NWATCH      = 3;   // watched signals: cs, sel, data
endpackage

// File: rtl/dlf_sync.sv
module dlf_sync #(
   parameter int W = 11,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("dlf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= din;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign dout = st[STAGES-1];
endmodule

// File: rtl/dlf_regs.sv
module dlf_regs #(
   parameter int DW = 8,
   parameter int NCH = 2,
   localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     act,
   input  logic [SELW-1:0]          sel,
   input  logic [DW-1:0]            d,
   output logic [NCH-1:0][DW-1:0]   q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (act && (sel == SELW'(c))) q[c] <= d;
         end
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chk
         assert_unsel_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (act && (sel != SELW'(g))) |=> $stable(q[g]));
         assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!act) |=> $stable(q[g]));
      end
   endgenerate
endmodule

// File: rtl/dlf_timing.sv
module dlf_timing
   import dlf_pkg::*;
#(
   parameter int DW = 8,
   parameter int SETUP_CYC = 4,
   parameter int HOLD_CYC = 2,
   parameter int PW_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              act,
   input  logic              cs_n_s,
   input  logic              sel_s,
   input  logic [DW-1:0]     d_s,
   output logic [NVIOL-1:0]  flags
);
   localparam int CMAX = (SETUP_CYC > PW_CYC) ? SETUP_CYC : PW_CYC;
   localparam int CW   = $clog2(CMAX + 1) + 1;
   localparam int HW   = $clog2(HOLD_CYC + 1) + 1;
   localparam logic [CW-1:0] SU_L = CW'(SETUP_CYC);
   localparam logic [CW-1:0] PW_L = CW'(PW_CYC);
   localparam logic [HW-1:0] HO_L = HW'(HOLD_CYC);

   generate
      if (SETUP_CYC < 1 || HOLD_CYC < 1 || PW_CYC < 1) begin : g_bad
         $error("dlf_timing: limits must be at least one cycle");
      end
   endgenerate

   logic              cs_q, sel_q, act_q;
   logic [DW-1:0]     d_q;
   logic [NWATCH-1:0] chg;
   logic [CW-1:0]     stab [NWATCH];
   logic [CW-1:0]     act_len;
   logic [HW-1:0]     hold_cnt;
   logic              end_w, in_win;
   logic [NVIOL-1:0]  set_v;

   assign chg[0] = cs_n_s != cs_q;
   assign chg[1] = sel_s  != sel_q;
   assign chg[2] = d_s    != d_q;
   assign end_w  = act_q && !act;
   assign in_win = end_w || (hold_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         sel_q    <= 1'b0;
         d_q      <= '0;
         act_q    <= 1'b0;
         act_len  <= '0;
         hold_cnt <= '0;
         for (int i = 0; i < NWATCH; i++) stab[i] <= SU_L;
      end else begin
         cs_q  <= cs_n_s;
         sel_q <= sel_s;
         d_q   <= d_s;
         act_q <= act;
         for (int i = 0; i < NWATCH; i++) begin
            if (chg[i])              stab[i] <= '0;
            else if (stab[i] < SU_L) stab[i] <= stab[i] + 1'b1;
         end
         if (!act)                act_len <= '0;
         else if (act_len < PW_L) act_len <= act_len + 1'b1;
         if (end_w)                 hold_cnt <= HO_L;
         else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
      end
   end

   always_comb begin
      set_v = '0;
      set_v[V_PW] = end_w && (act_len < PW_L);
      for (int i = 0; i < NWATCH; i++) begin
         set_v[V_SU_BASE + i] = end_w && (stab[i] < SU_L);
         set_v[V_HO_BASE + i] = in_win && chg[i];
      end
      set_v[V_SEL_MID] = act && act_q && chg[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags <= '0;
      else if (clr) flags <= '0;
      else          flags <= flags | set_v;
   end

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> ((flags & $past(flags)) == $past(flags)));
   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags == '0));
endmodule

// File: rtl/dual_latch_front.sv
module dual_latch_front
   import dlf_pkg::*;
#(
   parameter int DW = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SETUP_CYC = 4,
   parameter int HOLD_CYC = 2,
   parameter int PW_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              viol_clr,
   input  logic [DW-1:0]     din,
   input  logic              ch_sel,
   input  logic              cs_n,
   input  logic              wr_n,
   output logic [DW-1:0]     code_a,
   output logic [DW-1:0]     code_b,
   output logic [NVIOL-1:0]  viol
);
   localparam int NCH = 2;
   localparam int SW  = DW + 3;
   localparam logic [SW-1:0] SYNC_RST = {{DW{1'b0}}, 1'b0, 1'b1, 1'b1};

   generate
      if (DW < 1) begin : g_bad
         $error("dual_latch_front: DW must be positive");
      end
   endgenerate

   logic [SW-1:0]         raw_v, syn_v;
   logic [DW-1:0]         d_s;
   logic                  sel_s, cs_s, wr_s, act_s;
   logic [NCH-1:0][DW-1:0] q;

   assign raw_v = {din, ch_sel, cs_n, wr_n};
   assign {d_s, sel_s, cs_s, wr_s} = syn_v;
   assign act_s = !cs_s && !wr_s;

   dlf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_v), .dout(syn_v)
   );

   dlf_regs #(.DW(DW), .NCH(NCH)) u_regs (
      .clk(clk), .rst_n(rst_n), .act(act_s), .sel(sel_s), .d(d_s), .q(q)
   );

   dlf_timing #(.DW(DW), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .PW_CYC(PW_CYC)) u_timing (
      .clk(clk), .rst_n(rst_n), .clr(viol_clr), .act(act_s),
      .cs_n_s(cs_s), .sel_s(sel_s), .d_s(d_s), .flags(viol)
   );

   assign code_a = q[0];
   assign code_b = q[1];
endmodule

// File: tb/sim_dual_latch_front.sv
module sim_dual_latch_front;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   typedef struct {
      logic [7:0] a;
      logic [7:0] b;
      logic [7:0] f;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       viol_clr = 1'b0;
   logic [7:0] din = 8'h00;
   logic       ch_sel = 1'b0;
   logic       cs_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] code_a, code_b, viol;

   int   checks = 0;
   int   errors = 0;
   int   pend = 0;
   bit   reported = 1'b0;
   exp_t exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_latch_front u0 (
      .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .din(din), .ch_sel(ch_sel),
      .cs_n(cs_n), .wr_n(wr_n), .code_a(code_a), .code_b(code_b), .viol(viol)
   );

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic cmp(string tag, string what, logic [7:0] got, logic [7:0] want);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, want);
      end
   endtask

   task automatic expect_state(logic [7:0] a, logic [7:0] b, logic [7:0] f, string tag);
      exp_t it;
      it.a = a; it.b = b; it.f = f; it.tag = tag;
      exp_q.push_back(it);
      pend++;
      wait (pend == 0);
   endtask

   // monitor: lets the sync and register stages settle, then compares away from the edge
   initial begin
      forever begin
         exp_t it;
         wait (pend != 0);
         repeat (6) @(posedge clk);
         @(negedge clk);
         it = exp_q.pop_front();
         cmp(it.tag, "code_a", code_a, it.a);
         cmp(it.tag, "code_b", code_b, it.b);
         cmp(it.tag, "viol",   viol,   it.f);
         pend--;
      end
   end

   task automatic clear_flags();
      @(negedge clk); viol_clr = 1'b1;
      @(negedge clk); viol_clr = 1'b0;
   endtask

   // lead: cycles before strobe falls; width: strobe low cycles; tail: cycles to cs rise
   task automatic wseq(logic s, logic [7:0] d, int lead, int width, int tail, int dchg, int schg);
      @(negedge clk);
      cs_n = 1'b0; ch_sel = s; din = d;
      repeat (lead) @(negedge clk);
      wr_n = 1'b0;
      repeat (width) @(negedge clk);
      wr_n = 1'b1;
      for (int k = 1; k <= tail; k++) begin
         @(negedge clk);
         if (k == dchg) din = ~din;
         if (k == schg) ch_sel = ~ch_sel;
      end
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got running exp done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_state(8'h00, 8'h00, 8'h00, "R1 reset");

      wseq(1'b0, 8'h5A, 2, 4, 4, 0, 0);
      expect_state(8'h5A, 8'h00, 8'h00, "R2 R5 write A");
      wseq(1'b1, 8'hC3, 2, 4, 4, 0, 0);
      expect_state(8'h5A, 8'hC3, 8'h00, "R2 R5 write B");

      wseq(1'b1, 8'h11, 4, 2, 4, 0, 0);
      expect_state(8'h5A, 8'h11, 8'h01, "R6 R11 short strobe");
      clear_flags();
      expect_state(8'h5A, 8'h11, 8'h00, "R10 clear");

      wseq(1'b0, 8'h22, 1, 3, 4, 0, 0);
      expect_state(8'h22, 8'h11, 8'h0E, "R7 R11 late setup");
      clear_flags();

      wseq(1'b1, 8'h33, 2, 4, 0, 0, 0);
      expect_state(8'h22, 8'h33, 8'h10, "R8 cs hold");
      clear_flags();

      wseq(1'b0, 8'h44, 2, 4, 4, 1, 0);
      expect_state(8'h44, 8'h33, 8'h40, "R8 R4 data hold");
      clear_flags();

      wseq(1'b1, 8'h55, 2, 4, 4, 0, 1);
      expect_state(8'h44, 8'h55, 8'h20, "R8 sel hold");
      clear_flags();
      expect_state(8'h44, 8'h55, 8'h00, "R10 clear after hold");

      // strobe pulses with chip select high: no effect
      @(negedge clk); ch_sel = 1'b0; din = 8'hEE;
      repeat (2) @(negedge clk); wr_n = 1'b0;
      repeat (5) @(negedge clk); wr_n = 1'b1;
      expect_state(8'h44, 8'h55, 8'h00, "R4 cs high ignores strobe");

      // transparency during an open write
      @(negedge clk); cs_n = 1'b0; din = 8'h66;
      repeat (2) @(negedge clk); wr_n = 1'b0;
      expect_state(8'h66, 8'h55, 8'h00, "R3 follow first");
      @(negedge clk); din = 8'h77;
      expect_state(8'h77, 8'h55, 8'h00, "R3 follow second");
      @(negedge clk); wr_n = 1'b1;
      repeat (4) @(negedge clk); cs_n = 1'b1;
      expect_state(8'h77, 8'h55, 8'h00, "R4 keep after end");

      // select flips during an open write
      @(negedge clk); cs_n = 1'b0; ch_sel = 1'b0; din = 8'h88;
      repeat (2) @(negedge clk); wr_n = 1'b0;
      expect_state(8'h88, 8'h55, 8'h00, "R5 B untouched");
      @(negedge clk); ch_sel = 1'b1;
      expect_state(8'h88, 8'h88, 8'h80, "R9 reroute");
      @(negedge clk); wr_n = 1'b1;
      repeat (4) @(negedge clk); cs_n = 1'b1;
      expect_state(8'h88, 8'h88, 8'h80, "R9 R10 sticky");
      clear_flags();
      expect_state(8'h88, 8'h88, 8'h00, "R10 final clear");

      report();
   end
endmodule